// File: doc/BRIEF.md
# Memory Self-Test Controller with Control Register

This block holds a 32-bit control/status word and runs a built-in self-test on a private word-wide SRAM that carries one parity bit per word. Software writes the run bit to launch a test. A sequencer then makes four full sweeps of the array: it writes a fixed pattern, reads it back and compares it, writes the inverted pattern, then reads and compares again. Stored parity is checked on every read in the first check sweep. A data mismatch and a parity fault each set their own sticky flag. When the test ends, the run bit clears by itself and a one-cycle done pulse is issued.

The same word also carries two software-owned bytes, a bus latency count and a cache line size, and a header-type byte that always reads zero. A capability bit always reads one. Outside a test, an external port reads and writes the SRAM. During a test that port is locked out. Each word costs one clock per sweep, so a test takes four clocks per word. A 1K-word array finishes inside the budget of a 33 MHz bus.

The sequencer states are IDLE, FILL_A, CHECK_A, FILL_B, CHECK_B and FINISH. The transitions are:
- IDLE→FILL_A when a start is accepted.
- FILL_A→CHECK_A, CHECK_A→FILL_B and FILL_B→CHECK_B, each after the last address of its sweep.
- CHECK_B→FINISH after the last read.
- FINISH→IDLE always.

Two inputs model array defects so that both flags can be exercised. A soft-reset input clears only the external read holding register and leaves the control word as it is.

Top module: `mbist_ctrl_reg`

## Requirements
- R1: After reset the control word reads 0x8000_0000, and bit 31 reads 1 at all times.
- R2: Writing 1 to bit 30 while no test runs starts a test in that cycle. From the next cycle bit 30 and `busy_o` read 1, and error bits 25 (parity) and 24 (mismatch) read 0.
- R3: If a start is accepted at clock edge k, `done_o` is high only in the cycle after edge k+4·DEPTH. After edge k+4·DEPTH+1, both bit 30 and `busy_o` read 0.
- R4: Bit 25 is set when a word read in the first check sweep has a stored parity bit that differs from the even parity of its data. It stays set until the next start.
- R5: Bit 24 is set when a word read back differs from the pattern written in that sweep. The first pattern is 0x5555_5555 and the second is 0xAAAA_AAAA. A cell with bit 0 stuck at 1 is therefore flagged only in the second sweep. The flag stays set until the next start.
- R6: A defect-free test leaves both error bits at 0, and every word of the array holds 0xAAAA_AAAA afterwards.
- R7: A write with bit 30 set while a test runs does not restart or extend that test.
- R8: Bits 15:8 (latency count) and 6:0 (line size) are read/write. Bits 29:26, 23:16 and 7 always read 0. Writes to bits 31, 25 and 24 have no effect.
- R9: `soft_rst` leaves the control word unchanged and clears `ext_rdata` to 0.
- R10: While idle, an external write stores its word. An external read issued at edge e shows its word on `ext_rdata` after edge e+1. While `busy_o` is high, external accesses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| soft_rst | input | 1 | Soft reset; clears only the external read holding register |
| cfg_wr_en | input | 1 | Control word write strobe |
| cfg_wr_data | input | 32 | Control word write data |
| cfg_rd_data | output | 32 | Current control word |
| ext_en | input | 1 | External SRAM access request |
| ext_we | input | 1 | External access is a write |
| ext_addr | input | ADDR_W | External word address |
| ext_wdata | input | DATA_W | External write data |
| ext_rdata | output | DATA_W | External read data holding register |
| flt_par_i | input | 1 | Defect model: store inverted parity |
| flt_stk_i | input | 1 | Defect model: data bit 0 stuck at 1 |
| busy_o | output | 1 | Test in progress, external port locked |
| done_o | output | 1 | One-cycle pulse at test end |

## Verification
The control word changes on the edge that accepts a write, so the bench reads it at the falling edge that follows. An accepted start raises `busy_o` one edge later. The bench then counts exactly 4·DEPTH edges and requires `done_o` at that count and never earlier. One edge after that, it requires the run bit and `busy_o` to be low and both flags to be final. Flags from the first check sweep are settled two edges after that sweep's last read, so the bench samples them at count 2·DEPTH+2, before any second-sweep compare can land. External reads are sampled after the second edge following the request.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL_A,
        ST_CHECK_A,
        ST_FILL_B,
        ST_CHECK_B,
        ST_FINISH
    } seq_state_t;

    localparam int unsigned CSR_W    = 32;
    localparam int unsigned BIT_CAP  = 31;
    localparam int unsigned BIT_RUN  = 30;
    localparam int unsigned BIT_PERR = 25;
    localparam int unsigned BIT_MISM = 24;
    localparam int unsigned LAT_LSB  = 8;
    localparam int unsigned LAT_W    = 8;
    localparam int unsigned CLS_W    = 7;

    localparam logic [CSR_W-1:0] CSR_RESET = 32'h8000_0000;

endpackage

// File: rtl/mbist_sram.sv
module mbist_sram #(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              flt_par,
    input  logic              flt_stk,
    output logic [DATA_W-1:0] rdata,
    output logic              rpar
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W:0]   mem [DEPTH];
    logic [DATA_W:0]   q;
    logic [DATA_W-1:0] stored;

    // defect model: bit 0 of every written word forced high
    assign stored = flt_stk ? (wdata | DATA_W'(1)) : wdata;

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                mem[addr] <= {(^stored) ^ flt_par, stored};
            end else begin
                q <= mem[addr];
            end
        end
    end

    assign rdata = q[DATA_W-1:0];
    assign rpar  = q[DATA_W];

endmodule

// File: rtl/mbist_seq.sv
module mbist_seq
    import mbist_pkg::*;
#(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned DATA_W = 32,
    parameter logic [DATA_W-1:0] PAT_A = {(DATA_W/2){2'b01}}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              rd_issue,
    output logic [DATA_W-1:0] exp_data,
    output logic              chk_par,
    output logic              busy,
    output logic              done
);
    localparam logic [DATA_W-1:0] PAT_B = ~PAT_A;

    seq_state_t        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic              last_addr;
    logic              sweeping;

    assign last_addr = &addr_q;
    assign sweeping  = (state_q != ST_IDLE) && (state_q != ST_FINISH);

    // state register and address counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            addr_q  <= sweeping ? addr_q + 1'b1 : '0;
        end
    end

    // next-state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start)     state_d = ST_FILL_A;
            ST_FILL_A:  if (last_addr) state_d = ST_CHECK_A;
            ST_CHECK_A: if (last_addr) state_d = ST_FILL_B;
            ST_FILL_B:  if (last_addr) state_d = ST_CHECK_B;
            ST_CHECK_B: if (last_addr) state_d = ST_FINISH;
            ST_FINISH:                 state_d = ST_IDLE;
            default:                   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_wdata = PAT_A;
        rd_issue  = 1'b0;
        exp_data  = PAT_A;
        chk_par   = 1'b0;
        busy      = 1'b1;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE:    busy = 1'b0;
            ST_FILL_A:  begin mem_en = 1'b1; mem_we = 1'b1; mem_wdata = PAT_A; end
            ST_CHECK_A: begin mem_en = 1'b1; rd_issue = 1'b1; exp_data = PAT_A; chk_par = 1'b1; end
            ST_FILL_B:  begin mem_en = 1'b1; mem_we = 1'b1; mem_wdata = PAT_B; end
            ST_CHECK_B: begin mem_en = 1'b1; rd_issue = 1'b1; exp_data = PAT_B; end
            ST_FINISH:  done = 1'b1;
            default:    busy = 1'b0;
        endcase
    end

    assign mem_addr = addr_q;

endmodule

// File: rtl/mbist_cmp.sv
module mbist_cmp #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [DATA_W-1:0] exp_data,
    input  logic              chk_par,
    input  logic [DATA_W-1:0] rdata,
    input  logic              rpar,
    output logic              perr,
    output logic              mism
);
    logic              vld_q;
    logic              chk_q;
    logic [DATA_W-1:0] exp_q;

    // align the expectation with the one-cycle array read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            chk_q <= 1'b0;
            exp_q <= '0;
        end else begin
            vld_q <= issue;
            chk_q <= chk_par;
            exp_q <= exp_data;
        end
    end

    assign perr = vld_q && chk_q && ((^rdata) != rpar);
    assign mism = vld_q && (rdata != exp_q);

endmodule

// File: rtl/mbist_csr.sv
module mbist_csr
    import mbist_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CSR_W-1:0] wr_data,
    input  logic             done,
    input  logic             perr,
    input  logic             mism,
    output logic [CSR_W-1:0] rd_data,
    output logic             start
);
    logic             run_q;
    logic             perr_q;
    logic             mism_q;
    logic [LAT_W-1:0] lat_q;
    logic [CLS_W-1:0] cls_q;
    logic             unused_wr;

    assign unused_wr = ^{wr_data[CSR_W-1], wr_data[29:16], wr_data[7]};

    // start is taken only when no test is running
    assign start = wr_en && wr_data[BIT_RUN] && !run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            perr_q <= 1'b0;
            mism_q <= 1'b0;
            lat_q  <= '0;
            cls_q  <= '0;
        end else begin
            if (wr_en) begin
                lat_q <= wr_data[LAT_LSB +: LAT_W];
                cls_q <= wr_data[CLS_W-1:0];
            end
            if (start) begin
                run_q  <= 1'b1;
                perr_q <= 1'b0;
                mism_q <= 1'b0;
            end else begin
                if (done) run_q  <= 1'b0;
                if (perr) perr_q <= 1'b1;
                if (mism) mism_q <= 1'b1;
            end
        end
    end

    always_comb begin
        rd_data                    = '0;
        rd_data[BIT_CAP]           = CSR_RESET[BIT_CAP];
        rd_data[BIT_RUN]           = run_q;
        rd_data[BIT_PERR]          = perr_q;
        rd_data[BIT_MISM]          = mism_q;
        rd_data[LAT_LSB +: LAT_W]  = lat_q;
        rd_data[CLS_W-1:0]         = cls_q;
    end

endmodule

// File: rtl/mbist_ctrl_reg.sv
module mbist_ctrl_reg
    import mbist_pkg::*;
#(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned DATA_W = 32,
    parameter logic [DATA_W-1:0] PAT_A = {(DATA_W/2){2'b01}}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              cfg_wr_en,
    input  logic [31:0]       cfg_wr_data,
    output logic [31:0]       cfg_rd_data,
    input  logic              ext_en,
    input  logic              ext_we,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic [DATA_W-1:0] ext_wdata,
    output logic [DATA_W-1:0] ext_rdata,
    input  logic              flt_par_i,
    input  logic              flt_stk_i,
    output logic              busy_o,
    output logic              done_o
);
    logic              start;
    logic              seq_en, seq_we, rd_issue, chk_par, busy, done;
    logic [ADDR_W-1:0] seq_addr;
    logic [DATA_W-1:0] seq_wdata, exp_data;
    logic              sram_en, sram_we;
    logic [ADDR_W-1:0] sram_addr;
    logic [DATA_W-1:0] sram_wdata, sram_rdata;
    logic              sram_rpar;
    logic              perr, mism;
    logic              ext_rd_q;
    logic [DATA_W-1:0] ext_rdata_q;

    mbist_csr u_csr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_data (cfg_wr_data),
        .done    (done),
        .perr    (perr),
        .mism    (mism),
        .rd_data (cfg_rd_data),
        .start   (start)
    );

    mbist_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAT_A(PAT_A)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .mem_en    (seq_en),
        .mem_we    (seq_we),
        .mem_addr  (seq_addr),
        .mem_wdata (seq_wdata),
        .rd_issue  (rd_issue),
        .exp_data  (exp_data),
        .chk_par   (chk_par),
        .busy      (busy),
        .done      (done)
    );

    // the sequencer owns the array while a test runs
    assign sram_en    = busy ? seq_en    : ext_en;
    assign sram_we    = busy ? seq_we    : ext_we;
    assign sram_addr  = busy ? seq_addr  : ext_addr;
    assign sram_wdata = busy ? seq_wdata : ext_wdata;

    mbist_sram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sram (
        .clk     (clk),
        .en      (sram_en),
        .we      (sram_we),
        .addr    (sram_addr),
        .wdata   (sram_wdata),
        .flt_par (flt_par_i),
        .flt_stk (flt_stk_i),
        .rdata   (sram_rdata),
        .rpar    (sram_rpar)
    );

    mbist_cmp #(.DATA_W(DATA_W)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue    (rd_issue),
        .exp_data (exp_data),
        .chk_par  (chk_par),
        .rdata    (sram_rdata),
        .rpar     (sram_rpar),
        .perr     (perr),
        .mism     (mism)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_rd_q    <= 1'b0;
            ext_rdata_q <= '0;
        end else begin
            ext_rd_q <= ext_en && !ext_we && !busy;
            if (soft_rst) begin
                ext_rdata_q <= '0;
            end else if (ext_rd_q) begin
                ext_rdata_q <= sram_rdata;
            end
        end
    end

    assign ext_rdata = ext_rdata_q;
    assign busy_o    = busy;
    assign done_o    = done;

endmodule

// File: rtl/mbist_ctrl_reg_chk.sv
module mbist_ctrl_reg_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        soft_rst,
    input logic        cfg_wr_en,
    input logic [31:0] cfg_rd_data,
    input logic        busy_o,
    input logic        done_o
);
    p_cap_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd_data[31]);

    p_start_clears_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_rd_data[30]) |-> (cfg_rd_data[25:24] == 2'b00));

    p_busy_tracks_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o == cfg_rd_data[30]);

    p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o && !cfg_rd_data[30]));

    p_rsvd_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd_data[29:26] == 4'h0) && (cfg_rd_data[23:16] == 8'h00) && !cfg_rd_data[7]);

    p_soft_keeps_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst && !cfg_wr_en && !busy_o) |=> $stable(cfg_rd_data));

endmodule

bind mbist_ctrl_reg mbist_ctrl_reg_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_rst    (soft_rst),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_rd_data (cfg_rd_data),
    .busy_o      (busy_o),
    .done_o      (done_o)
);

// File: tb/test_mbist_ctrl_reg.sv
`timescale 1ns/1ps
module test_mbist_ctrl_reg;
    localparam int AW = 4;
    localparam int N  = 1 << AW;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n, soft_rst, cfg_wr_en, ext_en, ext_we, flt_par_i, flt_stk_i;
    logic [31:0]   cfg_wr_data, cfg_rd_data;
    logic [AW-1:0] ext_addr;
    logic [DW-1:0] ext_wdata, ext_rdata;
    logic          busy_o, done_o;

    int n_chk = 0;
    int n_bad = 0;
    bit fin   = 1'b0;
    logic [7:0] lat_v = 8'h3C;
    logic [6:0] cls_v = 7'd8;

    always #10 clk = ~clk;

    mbist_ctrl_reg #(.ADDR_W(AW), .DATA_W(DW)) i_mbist_ctrl_reg (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data), .cfg_rd_data(cfg_rd_data),
        .ext_en(ext_en), .ext_we(ext_we), .ext_addr(ext_addr),
        .ext_wdata(ext_wdata), .ext_rdata(ext_rdata),
        .flt_par_i(flt_par_i), .flt_stk_i(flt_stk_i),
        .busy_o(busy_o), .done_o(done_o)
    );

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] cfg_word(input bit go);
        return {1'b0, go, 14'h0, lat_v, 1'b0, cls_v};
    endfunction

    task automatic cfg_write(input logic [31:0] d);
        cfg_wr_en = 1'b1; cfg_wr_data = d;
        tick;
        cfg_wr_en = 1'b0; cfg_wr_data = '0;
    endtask

    task automatic ext_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        ext_en = 1'b1; ext_we = 1'b1; ext_addr = a; ext_wdata = d;
        tick;
        ext_en = 1'b0; ext_we = 1'b0;
    endtask

    task automatic ext_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
        ext_en = 1'b1; ext_we = 1'b0; ext_addr = a;
        tick;
        ext_en = 1'b0;
        tick;
        d = ext_rdata;
    endtask

    task automatic run_bist(input bit fp, input bit fs, input bit poke, input logic [31:0] exp_word);
        bit early;
        flt_par_i = fp; flt_stk_i = fs;
        cfg_write(cfg_word(1'b1));
        chk(busy_o === 1'b1 && cfg_rd_data[30] === 1'b1, "R2 start accepted",
            {busy_o, cfg_rd_data[30]}, 32'h3);
        chk(cfg_rd_data[25:24] === 2'b00, "R2 flags cleared on start",
            cfg_rd_data[25:24], 32'h0);
        early = 1'b0;
        for (int c = 1; c <= 4*N; c++) begin
            if (poke && c == 5) begin
                ext_en = 1'b1; ext_we = 1'b1; ext_addr = 3; ext_wdata = 32'h1234_5678;
                cfg_wr_en = 1'b1; cfg_wr_data = cfg_word(1'b1);
            end
            tick;
            if (poke && c == 5) begin
                ext_en = 1'b0; ext_we = 1'b0; cfg_wr_en = 1'b0; cfg_wr_data = '0;
            end
            if (c < 4*N && done_o) early = 1'b1;
            if (c == 2*N+2)
                chk(cfg_rd_data[25] === exp_word[25] && cfg_rd_data[24] === 1'b0,
                    "R4/R5 flags after first check sweep",
                    cfg_rd_data[25:24], {exp_word[25], 1'b0});
        end
        chk(!early, "R3/R7 no early done", early, 0);
        chk(done_o === 1'b1, "R3 done at 4*DEPTH", done_o, 1);
        tick;
        chk(done_o === 1'b0 && busy_o === 1'b0 && cfg_rd_data[30] === 1'b0,
            "R3 idle after done", {done_o, busy_o, cfg_rd_data[30]}, 0);
        chk(cfg_rd_data === exp_word, "R4/R5/R6 final word", cfg_rd_data, exp_word);
        flt_par_i = 1'b0; flt_stk_i = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!fin) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] rd;
        logic [31:0]   held;
        rst_n = 1'b0; soft_rst = 1'b0; cfg_wr_en = 1'b0; cfg_wr_data = '0;
        ext_en = 1'b0; ext_we = 1'b0; ext_addr = '0; ext_wdata = '0;
        flt_par_i = 1'b0; flt_stk_i = 1'b0;
        repeat (3) tick;
        rst_n = 1'b1;
        tick;

        // R1 reset state
        chk(cfg_rd_data === 32'h8000_0000, "R1 reset word", cfg_rd_data, 32'h8000_0000);
        chk(busy_o === 1'b0 && done_o === 1'b0, "R1 idle outputs", {busy_o, done_o}, 0);

        // R8 sweep of every line-size value with a derived latency byte
        for (int i = 0; i < 128; i++) begin
            logic [7:0] l;
            logic [6:0] s;
            l = 8'(i) ^ 8'h5A;
            s = 7'(i);
            cfg_write(32'hBFFF_0080 | {16'h0, l, 1'b0, s});
            chk(cfg_rd_data === (32'h8000_0000 | {16'h0, l, 1'b0, s}), "R8 field sweep",
                cfg_rd_data, 32'h8000_0000 | {16'h0, l, 1'b0, s});
        end
        cfg_write(cfg_word(1'b0));
        chk(cfg_rd_data === 32'h8000_3C08, "R8 final fields", cfg_rd_data, 32'h8000_3C08);

        // R10 external access sweep over all addresses
        for (int a = 0; a < N; a++)
            ext_write(AW'(a), (32'(a) * 32'h0101_0101) ^ 32'hC3A5_0F00);
        for (int a = 0; a < N; a++) begin
            ext_read(AW'(a), rd);
            chk(rd === ((32'(a) * 32'h0101_0101) ^ 32'hC3A5_0F00), "R10 external readback",
                rd, (32'(a) * 32'h0101_0101) ^ 32'hC3A5_0F00);
        end

        // R9 soft reset
        held = cfg_rd_data;
        soft_rst = 1'b1;
        tick;
        soft_rst = 1'b0;
        chk(cfg_rd_data === held, "R9 word unchanged", cfg_rd_data, held);
        chk(ext_rdata === '0, "R9 read holding cleared", ext_rdata, 0);

        // R4 parity defect, R5 stuck bit, both, then defect-free with pokes (R6, R7, R10)
        run_bist(1'b1, 1'b0, 1'b0, 32'h8200_3C08);
        run_bist(1'b0, 1'b1, 1'b0, 32'h8100_3C08);
        run_bist(1'b1, 1'b1, 1'b0, 32'h8300_3C08);
        run_bist(1'b0, 1'b0, 1'b1, 32'h8000_3C08);

        for (int a = 0; a < N; a++) begin
            ext_read(AW'(a), rd);
            chk(rd === 32'hAAAA_AAAA, "R6/R10 array after test", rd, 32'hAAAA_AAAA);
        end

        fin = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule